// File: doc/BRIEF.md
# Linear Sensor Readout Sequencer

This block is the digital timing core of a linear photodiode array that has 1024 physical pixels. It runs at the pixel rate. On each clock it gives the index of the binned pixel group whose value drives the video output, together with a flag that marks that index as valid. A start input launches a scan. A hold input keeps the scan logic cleared. When hold and start are high at the same time, the block enters a low-power standby. The analog parts of the array are not modelled here: the block only emits indices and enables.

A two-bit bin select sets how many neighbouring pixels form one output group, so the number of clocks per frame equals the chosen resolution. The block has two reset styles:
- **Frame mode:** a global pixel reset is raised while hold and shutter are both high.
- **Dynamic mode:** each group receives its own reset strobe in the cycle after it is read out, while the next group is being read.

Column amplifier lanes that a coarser binning leaves unused are disabled. All outputs are registered and appear one clock after the edge that caused them.

Top module: `lsr_seq`

## Requirements
- R1: `bin_sel` 2'b00, 2'b01, 2'b10 and 2'b11 select 1024, 512, 256 and 128 groups. A frame shows `grp_idx` rising by one per clock from 0 to groups-1, with `vid_valid` high for exactly that many clocks.
- R2: A rising edge with `start` high and `scan_hold` low makes `vid_valid` high and `grp_idx` 0 after that edge.
- R3: `start` high at any later edge of a running frame restarts the scan at group 0. Holding `start` high repeats group 0.
- R4: After the last group, `vid_valid` goes low and `grp_idx` holds its value until the next start.
- R5: While `scan_hold` is high, `vid_valid` is low and the scan index is 0. The next start after release begins at group 0.
- R6: An edge with both `scan_hold` and `start` high makes `standby` 1, `out_en` 0 and `amp_en` all zero after it. Any other edge makes `standby` 0 and `out_en` 1.
- R7: `pix_rst` is high after an edge exactly when `scan_hold` and `shutter` were high, `dyn_mode` was low and `start` was low.
- R8: In dynamic mode, every clock with `vid_valid` high is followed by one clock with `trail_rst` high and `trail_idx` equal to that group, including the last group. In frame mode, `trail_rst` stays low. `trail_idx` holds its value otherwise.
- R9: Amplifier lane l (pixel p uses lane p mod 8) is enabled exactly when l is a multiple of the bin factor 1, 2, 4 or 8 of the latched bin select.
- R10: In dynamic mode, the first frame started after a hold or a reset has `vid_stale` high on all of its valid clocks. Later frames have it low. It is low in frame mode.
- R11: `bin_sel` and `dyn_mode` are latched only while `scan_hold` is high, or on a start from idle. Changes during a frame have no effect on that frame.
- R12: With `rst_n` low at a clock edge, all outputs are 0, the latched mode is 1024 groups in frame mode, and the next dynamic frame is marked stale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_hold | input | 1 | Holds the scan cleared; with start, enters standby |
| shutter | input | 1 | Shutter level for frame-mode pixel reset |
| start | input | 1 | Starts or restarts a readout scan |
| bin_sel | input | 2 | Bin select (00:1024, 01:512, 10:256, 11:128 groups) |
| dyn_mode | input | 1 | 1 selects per-group dynamic reset, 0 selects frame mode |
| grp_idx | output | 10 | Index of the group being output |
| vid_valid | output | 1 | grp_idx carries a valid group |
| vid_stale | output | 1 | Current dynamic frame has unknown integration time |
| trail_rst | output | 1 | Per-group reset strobe in dynamic mode |
| trail_idx | output | 10 | Group being reset by trail_rst |
| pix_rst | output | 1 | Global pixel reset in frame mode |
| amp_en | output | 8 | Column amplifier lane enables |
| out_en | output | 1 | Output amplifier enable |
| standby | output | 1 | Standby indication |

## Verification
The assertions assume that every input changes away from the rising clock edge and is stable while the edge samples it. They also assume that `rst_n` is held low for at least one edge before any check is made. The bench drives every input on the falling edge only and holds reset low for several cycles at the start. It keeps dynamic mode with `scan_hold` low, except for deliberate hold and standby pulses. It changes `bin_sel` and `dyn_mode` mid-frame only to show that those changes are ignored. Under these conditions, the trailing-reset and step properties only see group indices that the latched bin select can produce.

// File: rtl/lsr_pkg.sv
// Shared types for the linear sensor readout sequencer.
package lsr_pkg;
    // Bin select encodings: number of physical pixels per output group.
    typedef enum logic [1:0] {
        BIN_X1 = 2'b00,
        BIN_X2 = 2'b01,
        BIN_X4 = 2'b10,
        BIN_X8 = 2'b11
    } bin_e;

    // Mode captured at the start of a frame (or while held).
    typedef struct packed {
        bin_e bin;
        logic dyn;
    } mode_t;
endpackage

// File: rtl/lsr_scan.sv
// Group scan counter. Starts at group 0 on start, steps once per clock
// up to the last group of the latched resolution, then idles holding the
// index. Latches the mode while held or on a start from idle, and tracks
// whether the next dynamic-mode frame has an unknown integration time.
// Assumes NPIX is a power of two of at least 8.
module lsr_scan
    import lsr_pkg::*;
#(
    parameter int NPIX  = 1024,
    parameter int IDX_W = $clog2(NPIX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_i,
    input  logic             start_i,
    input  mode_t            mode_in,
    output mode_t            mode_q,
    output logic [IDX_W-1:0] idx_q,
    output logic             valid_q,
    output logic             stale_o
);
    localparam logic [IDX_W:0] NPIX_W = (IDX_W+1)'(NPIX);

    logic [IDX_W:0]   last_w;
    logic [IDX_W-1:0] last_idx;
    logic             stale_q;
    logic             pend_q;

    // Last group index for the latched bin factor.
    always_comb begin
        last_w   = (NPIX_W >> mode_q.bin) - 1'b1;
        last_idx = last_w[IDX_W-1:0];
    end

    // Scan state, mode latch and stale-frame tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            idx_q   <= '0;
            mode_q  <= '{bin: BIN_X1, dyn: 1'b0};
            stale_q <= 1'b0;
            pend_q  <= 1'b1;
        end else if (hold_i) begin
            valid_q <= 1'b0;
            idx_q   <= '0;
            mode_q  <= mode_in;
            stale_q <= 1'b0;
            pend_q  <= 1'b1;
        end else if (start_i) begin
            if (!valid_q) begin
                mode_q <= mode_in;
                if (mode_in.dyn) begin
                    stale_q <= pend_q;
                    pend_q  <= 1'b0;
                end else begin
                    stale_q <= 1'b0;
                end
            end
            idx_q   <= '0;
            valid_q <= 1'b1;
        end else if (valid_q) begin
            if (idx_q == last_idx) begin
                valid_q <= 1'b0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign stale_o = stale_q & valid_q;
endmodule

// File: rtl/lsr_trail.sv
// Dynamic-mode trailing reset: one clock after a group is read out in
// dynamic mode, strobes a reset for that group. Assumes its inputs come
// from the scan registers of the same clock.
module lsr_trail #(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic             dyn_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic             strobe_q,
    output logic [IDX_W-1:0] ridx_q
);
    // Delay the read group by one clock into the reset strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
            ridx_q   <= '0;
        end else begin
            strobe_q <= valid_i & dyn_i;
            if (valid_i && dyn_i) begin
                ridx_q <= idx_i;
            end
        end
    end
endmodule

// File: rtl/lsr_power.sv
// Power and reset control: standby decode, output enable, amplifier lane
// mask for the latched binning, and the frame-mode global pixel reset.
// Assumes LANES is a multiple of 8 so that every bin factor divides it.
module lsr_power
    import lsr_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_i,
    input  logic             start_i,
    input  logic             shutter_i,
    input  logic             dyn_i,
    input  bin_e             bin_i,
    output logic             standby_q,
    output logic             oe_q,
    output logic [LANES-1:0] amp_q,
    output logic             pixrst_q
);
    logic [LANES-1:0] lane_mask;
    logic             stby_next;

    // A lane is needed when its number is a multiple of the bin factor.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam logic [2:0] LLOW = 3'(l % 8);
        always_comb begin
            case (bin_i)
                BIN_X1:  lane_mask[l] = 1'b1;
                BIN_X2:  lane_mask[l] = (LLOW[0] == 1'b0);
                BIN_X4:  lane_mask[l] = (LLOW[1:0] == 2'b00);
                default: lane_mask[l] = (LLOW == 3'b000);
            endcase
        end
    end

    assign stby_next = hold_i & start_i;

    // Register standby, enables and the global pixel reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            standby_q <= 1'b0;
            oe_q      <= 1'b0;
            amp_q     <= '0;
            pixrst_q  <= 1'b0;
        end else begin
            standby_q <= stby_next;
            oe_q      <= ~stby_next;
            amp_q     <= stby_next ? '0 : lane_mask;
            pixrst_q  <= hold_i & shutter_i & ~dyn_i & ~start_i;
        end
    end
endmodule

// File: rtl/lsr_seq.sv
// Top of the linear sensor readout sequencer. Ties together the scan
// counter, the dynamic-mode trailing reset and the power control.
// Assumes all inputs are synchronous to clk.
module lsr_seq
    import lsr_pkg::*;
#(
    parameter int NPIX  = 1024,
    parameter int LANES = 8,
    parameter int IDX_W = $clog2(NPIX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scan_hold,
    input  logic             shutter,
    input  logic             start,
    input  logic [1:0]       bin_sel,
    input  logic             dyn_mode,
    output logic [IDX_W-1:0] grp_idx,
    output logic             vid_valid,
    output logic             vid_stale,
    output logic             trail_rst,
    output logic [IDX_W-1:0] trail_idx,
    output logic             pix_rst,
    output logic [LANES-1:0] amp_en,
    output logic             out_en,
    output logic             standby
);
    mode_t      mode_in;
    mode_t      mode_q;
    logic [1:0] lat_bin;
    logic       lat_dyn;

    assign mode_in = '{bin: bin_e'(bin_sel), dyn: dyn_mode};
    assign lat_bin = mode_q.bin;
    assign lat_dyn = mode_q.dyn;

    lsr_scan #(.NPIX(NPIX), .IDX_W(IDX_W)) u_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold_i  (scan_hold),
        .start_i (start),
        .mode_in (mode_in),
        .mode_q  (mode_q),
        .idx_q   (grp_idx),
        .valid_q (vid_valid),
        .stale_o (vid_stale)
    );

    lsr_trail #(.IDX_W(IDX_W)) u_trail (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (vid_valid),
        .dyn_i    (mode_q.dyn),
        .idx_i    (grp_idx),
        .strobe_q (trail_rst),
        .ridx_q   (trail_idx)
    );

    lsr_power #(.LANES(LANES)) u_power (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_i    (scan_hold),
        .start_i   (start),
        .shutter_i (shutter),
        .dyn_i     (dyn_mode),
        .bin_i     (mode_q.bin),
        .standby_q (standby),
        .oe_q      (out_en),
        .amp_q     (amp_en),
        .pixrst_q  (pix_rst)
    );
endmodule

// File: rtl/lsr_seq_chk.sv
// Property checker for lsr_seq, attached with bind below.
module lsr_seq_chk #(
    parameter int NPIX  = 1024,
    parameter int LANES = 8,
    parameter int IDX_W = $clog2(NPIX)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scan_hold,
    input logic             shutter,
    input logic             start,
    input logic [IDX_W-1:0] grp_idx,
    input logic             vid_valid,
    input logic             trail_rst,
    input logic [IDX_W-1:0] trail_idx,
    input logic             pix_rst,
    input logic [LANES-1:0] amp_en,
    input logic             out_en,
    input logic             standby,
    input logic [1:0]       lat_bin,
    input logic             lat_dyn
);
    logic [IDX_W:0]   last_w;
    logic [IDX_W-1:0] last_g;

    // Last group index from the latched bin select.
    always_comb begin
        last_w = ((IDX_W+1)'(NPIX) >> lat_bin) - 1'b1;
        last_g = last_w[IDX_W-1:0];
    end

    assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        vid_valid && !start && !scan_hold && grp_idx != last_g
        |=> vid_valid && grp_idx == $past(grp_idx) + 1'b1);

    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start && !scan_hold |=> vid_valid && grp_idx == '0);

    assert_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vid_valid && !start && !scan_hold && grp_idx == last_g
        |=> !vid_valid && $stable(grp_idx));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        scan_hold |=> !vid_valid && grp_idx == '0);

    assert_standby_R6: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> amp_en == '0 && !out_en);

    assert_pixrst_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pix_rst |-> $past(scan_hold) && $past(shutter));

    assert_trail_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vid_valid && lat_dyn |=> trail_rst && trail_idx == $past(grp_idx));
endmodule

bind lsr_seq lsr_seq_chk #(.NPIX(NPIX), .LANES(LANES), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scan_hold (scan_hold),
    .shutter   (shutter),
    .start     (start),
    .grp_idx   (grp_idx),
    .vid_valid (vid_valid),
    .trail_rst (trail_rst),
    .trail_idx (trail_idx),
    .pix_rst   (pix_rst),
    .amp_en    (amp_en),
    .out_en    (out_en),
    .standby   (standby),
    .lat_bin   (lat_bin),
    .lat_dyn   (lat_dyn)
);

// File: tb/tb_lsr_seq.sv
`timescale 1ns/1ps
// Bench for lsr_seq: behavioural reference model stepped and compared on
// every clock; inputs driven on falling edges.
module tb_lsr_seq;
    localparam int NPIX = 1024;
    localparam int LANES = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scan_hold = 1'b0, shutter = 1'b0, start = 1'b0, dyn_mode = 1'b0;
    logic [1:0] bin_sel = 2'b00;
    logic [9:0] grp_idx, trail_idx;
    logic       vid_valid, vid_stale, trail_rst, pix_rst, out_en, standby;
    logic [7:0] amp_en;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    bit done = 0;
    string scen = "R12";

    // Reference model state
    int m_val, m_idx, m_bin, m_dyn, m_pend, m_stale;
    int m_str, m_ridx, m_stby, m_oe, m_amp, m_pix;

    always #10 clk = ~clk;

    lsr_seq #(.NPIX(NPIX), .LANES(LANES)) dut (
        .clk(clk), .rst_n(rst_n), .scan_hold(scan_hold), .shutter(shutter),
        .start(start), .bin_sel(bin_sel), .dyn_mode(dyn_mode),
        .grp_idx(grp_idx), .vid_valid(vid_valid), .vid_stale(vid_stale),
        .trail_rst(trail_rst), .trail_idx(trail_idx), .pix_rst(pix_rst),
        .amp_en(amp_en), .out_en(out_en), .standby(standby));

    function automatic int lane_mask(int bin);
        int m = 0;
        for (int l = 0; l < LANES; l++)
            if ((l % (1 << bin)) == 0) m |= (1 << l);
        return m;
    endfunction

    // Advance the model by one rising edge with the inputs it sampled.
    task automatic model_step(input bit r, h, sh, st, input int bs, input bit dm);
        int n_val = m_val, n_idx = m_idx, n_bin = m_bin, n_dyn = m_dyn;
        int n_pend = m_pend, n_stale = m_stale;
        if (!r) begin
            m_val = 0; m_idx = 0; m_bin = 0; m_dyn = 0; m_pend = 1; m_stale = 0;
            m_str = 0; m_ridx = 0; m_stby = 0; m_oe = 0; m_amp = 0; m_pix = 0;
            return;
        end
        m_str = (m_val && m_dyn) ? 1 : 0;
        if (m_str) m_ridx = m_idx;
        m_stby = (h && st) ? 1 : 0;
        m_oe = m_stby ? 0 : 1;
        m_amp = m_stby ? 0 : lane_mask(m_bin);
        m_pix = (h && sh && !dm && !st) ? 1 : 0;
        if (h) begin
            n_val = 0; n_idx = 0; n_bin = bs; n_dyn = dm; n_pend = 1; n_stale = 0;
        end else if (st) begin
            if (!m_val) begin
                n_bin = bs; n_dyn = dm;
                if (dm) begin n_stale = m_pend; n_pend = 0; end
                else n_stale = 0;
            end
            n_val = 1; n_idx = 0;
        end else if (m_val) begin
            if (m_idx == (NPIX >> m_bin) - 1) n_val = 0;
            else n_idx = m_idx + 1;
        end
        m_val = n_val; m_idx = n_idx; m_bin = n_bin; m_dyn = n_dyn;
        m_pend = n_pend; m_stale = n_stale;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s (%s) t=%0t actual=%0d expected=%0d", req, scen, $time, act, exp);
        end
    endtask

    // Drive inputs for n clocks, stepping and comparing after each edge.
    task automatic cyc(input bit h, sh, st, input int bs, input bit dm, input int n);
        for (int i = 0; i < n; i++) begin
            scan_hold = h; shutter = sh; start = st; bin_sel = 2'(bs); dyn_mode = dm;
            @(posedge clk);
            model_step(rst_n, h, sh, st, bs, dm);
            @(negedge clk);
            vectors++;
            chk("R1 grp_idx", grp_idx, m_idx);
            chk("R2 vid_valid", vid_valid, m_val);
            chk("R10 vid_stale", vid_stale, m_stale && m_val);
            chk("R8 trail_rst", trail_rst, m_str);
            chk("R8 trail_idx", trail_idx, m_ridx);
            chk("R7 pix_rst", pix_rst, m_pix);
            chk("R9 amp_en", amp_en, m_amp);
            chk("R6 out_en", out_en, m_oe);
            chk("R6 standby", standby, m_stby);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    // Watchdog: an overlong run counts as a failure.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                miscompares++;
                $display("FAIL watchdog expired at cycle %0d expected < 150000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        @(negedge clk);
        // R12: synchronous reset state
        scen = "R12"; rst_n = 1'b0;
        cyc(0, 0, 0, 0, 0, 4);
        rst_n = 1'b1;
        // R7: frame-mode global pixel reset while hold and shutter high
        scen = "R7";
        cyc(1, 1, 0, 0, 0, 3);
        cyc(0, 1, 0, 0, 0, 5);
        cyc(0, 0, 0, 0, 0, 2);
        // R1 R2 R4: full 1024 frame then idle holding index
        scen = "R1 R2 R4 full";
        cyc(0, 0, 1, 0, 0, 1);
        cyc(0, 0, 0, 0, 0, 1030);
        // R1 R9: each coarser binning
        for (int b = 1; b < 4; b++) begin
            scen = "R1 R9 binned";
            cyc(0, 0, 1, b, 0, 1);
            cyc(0, 0, 0, b, 0, (NPIX >> b) + 3);
        end
        // R11: bin_sel and dyn_mode change mid-frame are ignored
        scen = "R11";
        cyc(0, 0, 1, 3, 0, 1);
        cyc(0, 0, 0, 0, 1, 60);
        cyc(0, 0, 0, 1, 1, 80);
        // R3: retrigger mid-frame and start held high
        scen = "R3";
        cyc(0, 0, 1, 2, 0, 1);
        cyc(0, 0, 0, 2, 0, 40);
        cyc(0, 0, 1, 2, 0, 3);
        cyc(0, 0, 0, 2, 0, 270);
        // R5: hold mid-frame clears scan, next start from 0
        scen = "R5";
        cyc(0, 0, 1, 2, 0, 1);
        cyc(0, 0, 0, 2, 0, 20);
        cyc(1, 0, 0, 2, 0, 3);
        cyc(0, 0, 0, 2, 0, 3);
        cyc(0, 0, 1, 2, 0, 1);
        cyc(0, 0, 0, 2, 0, 260);
        // R6: standby entry and exit
        scen = "R6";
        cyc(1, 1, 1, 1, 0, 6);
        cyc(0, 0, 0, 1, 0, 3);
        // R8 R10: dynamic mode after hold, back-to-back frames
        scen = "R8 R10 dyn";
        cyc(1, 1, 0, 3, 1, 2);
        cyc(0, 1, 0, 3, 1, 2);
        cyc(0, 1, 1, 3, 1, 1);
        cyc(0, 1, 0, 3, 1, 127);
        cyc(0, 1, 1, 3, 1, 1);
        cyc(0, 1, 0, 3, 1, 130);
        cyc(0, 1, 1, 3, 1, 1);
        cyc(0, 1, 0, 3, 1, 131);
        // R10: standby also marks next dynamic frame stale
        scen = "R10 R6 dyn";
        cyc(1, 1, 1, 3, 1, 2);
        cyc(0, 1, 1, 3, 1, 1);
        cyc(0, 1, 0, 3, 1, 131);
        // R12: reset in mid-frame
        scen = "R12 mid";
        cyc(0, 1, 1, 2, 1, 1);
        cyc(0, 1, 0, 2, 1, 10);
        rst_n = 1'b0;
        cyc(0, 0, 0, 2, 1, 2);
        rst_n = 1'b1;
        cyc(0, 0, 1, 3, 1, 1);
        cyc(0, 0, 0, 3, 1, 130);
        finish_run();
    end
endmodule